// File: doc/BRIEF.md
# Reset-Time Configuration Stream Generator

This block stands in for the small EPROM or PAL that feeds a processor its reset-time configuration over a slow serial line. Configuration fields arrive as static inputs: data pattern, pipeline clock ratio, byte order, write protocol, timer interrupt disable, 32-bit bus select, drive strength, address-to-data delay and fast-multiply disable. When a reset-mode request arrives, the block checks the fields and puts them into a fixed frame. It then shifts the frame out, lowest bit first. Each bit is held for a programmable number of system clock cycles, 256 by default. A companion serial clock rises in the middle of each bit period.

Reserved frame positions are always sent as zero. A requested code that falls in a reserved encoding is replaced by a safe default, and an error flag is raised for that frame. A one-cycle done pulse marks the end of the stream.

Top module: `bootcfg_serializer`

## Requirements
- R1: On the clock edge that samples `start` high while idle, frame bit 0 appears on `ser_data`. Each frame bit k is then held for exactly DIV cycles, so bit k is present from cycle k*DIV to cycle k*DIV+DIV-1, counted from that edge.
- R2: Within each bit period, `ser_clk` is 0 for the first DIV/2 cycles and 1 for the remaining cycles. While idle, `ser_clk` and `ser_data` are 0.
- R3: The data pattern sits in frame bits 4..1 with bit 4 as MSB. The clock ratio sits in bits 7..5 with bit 7 as MSB. Byte order (1 = big endian) is bit 8. The write protocol sits in bits 10..9 with bit 10 as MSB.
- R4: Bit 11 is timer-interrupt-disable, bit 12 is 32-bit bus select, bits 14..13 are drive strength (MSB 14), bits 15..17 are the address-to-data delay (MSB 17), and bit 19 is fast-multiply-disable.
- R5: Bit 0, bit 18 and every bit from 20 to FRAME_LEN-1 are sent as 0, whatever the inputs are.
- R6: Clock ratio code 7 is reserved. It is sent as code 0 and sets `cfg_err` for that frame.
- R7: Write protocol code 01 is reserved. It is sent as 00 and sets `cfg_err`.
- R8: Data pattern codes 9..15 are reserved. They are sent as 0 and set `cfg_err`.
- R9: `done` is high for exactly one cycle, at cycle FRAME_LEN*DIV after the start edge. On that same edge `busy` falls.
- R10: A `start` asserted while `busy` is high is ignored. Input changes during a frame do not alter it.
- R11: `cfg_err` is updated only when a frame starts and holds its value until the next start. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Reset-mode request; starts a frame when idle |
| cfg_pattern | input | 4 | Transmit data pattern code |
| cfg_ratio | input | 3 | Pipeline clock ratio code (0..6 = x2..x8) |
| cfg_big_endian | input | 1 | 1 selects big endian |
| cfg_wmode | input | 2 | Write protocol: 00 legacy, 10 pipelined, 11 reissue |
| cfg_timer_off | input | 1 | 1 disables timer interrupt |
| cfg_bus32 | input | 1 | 1 selects 32-bit system interface |
| cfg_drive | input | 2 | Output drive strength code |
| cfg_wdelay | input | 3 | Write address to data delay, 0..7 cycles |
| cfg_nofastmul | input | 1 | 1 disables fast multiply |
| ser_clk | output | 1 | Divided serial clock |
| ser_data | output | 1 | Serial configuration bit |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| cfg_err | output | 1 | A reserved code was replaced in the current frame |

## Verification
The bench builds the block with DIV=4 and FRAME_LEN=32. This keeps a whole frame at 128 cycles, so every cycle of every frame can be compared. It still covers all configured fields, the zero-forced positions 18 and 20..31, and both halves of the serial clock. Sixteen frames sweep every data pattern code, cycle every clock ratio and write protocol code (including the reserved ones), and vary the single-bit and small fields arithmetically. Extra runs cover a start request in the middle of a frame and back-to-back frames in which the error flag changes.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;

  typedef struct packed {
    logic [3:0] pattern;
    logic [2:0] ratio;
    logic       big_endian;
    logic [1:0] wmode;
    logic       timer_off;
    logic       bus32;
    logic [1:0] drive;
    logic [2:0] wdelay;
    logic       nofastmul;
  } bootcfg_t;

  // Frame positions (receiver decodes these)
  localparam int POS_PATTERN = 1;
  localparam int POS_RATIO   = 5;
  localparam int POS_ENDIAN  = 8;
  localparam int POS_WMODE   = 9;
  localparam int POS_TIMER   = 11;
  localparam int POS_BUS     = 12;
  localparam int POS_DRIVE   = 13;
  localparam int POS_WDELAY  = 15;
  localparam int POS_ZERO18  = 18;
  localparam int POS_FASTMUL = 19;
  localparam int FIELD_END   = 20;

  localparam logic [2:0] RATIO_RSVD  = 3'd7;
  localparam logic [1:0] WMODE_RSVD  = 2'b01;
  localparam logic [3:0] PATTERN_MAX = 4'd8;

  localparam logic [2:0] RATIO_SAFE   = 3'd0;
  localparam logic [1:0] WMODE_SAFE   = 2'b00;
  localparam logic [3:0] PATTERN_SAFE = 4'd0;

endpackage

// File: rtl/bootcfg_validate.sv
module bootcfg_validate
  import bootcfg_pkg::*;
(
  input  bootcfg_t cfg_in,
  output bootcfg_t cfg_out,
  output logic     bad_ratio,
  output logic     bad_wmode,
  output logic     bad_pattern
);

  always_comb begin
    bad_ratio   = (cfg_in.ratio == RATIO_RSVD);
    bad_wmode   = (cfg_in.wmode == WMODE_RSVD);
    bad_pattern = (cfg_in.pattern > PATTERN_MAX);
    cfg_out         = cfg_in;
    if (bad_ratio)   cfg_out.ratio   = RATIO_SAFE;
    if (bad_wmode)   cfg_out.wmode   = WMODE_SAFE;
    if (bad_pattern) cfg_out.pattern = PATTERN_SAFE;
  end

endmodule

// File: rtl/bootcfg_frame_build.sv
module bootcfg_frame_build
  import bootcfg_pkg::*;
#(
  parameter int FRAME_LEN = 256
) (
  input  bootcfg_t               cfg,
  output logic [FRAME_LEN-1:0]   frame
);

  assign frame[0]                            = 1'b0;
  assign frame[POS_PATTERN+3:POS_PATTERN]    = cfg.pattern;
  assign frame[POS_RATIO+2:POS_RATIO]        = cfg.ratio;
  assign frame[POS_ENDIAN]                   = cfg.big_endian;
  assign frame[POS_WMODE+1:POS_WMODE]        = cfg.wmode;
  assign frame[POS_TIMER]                    = cfg.timer_off;
  assign frame[POS_BUS]                      = cfg.bus32;
  assign frame[POS_DRIVE+1:POS_DRIVE]        = cfg.drive;
  assign frame[POS_WDELAY+2:POS_WDELAY]      = cfg.wdelay;
  assign frame[POS_ZERO18]                   = 1'b0;
  assign frame[POS_FASTMUL]                  = cfg.nofastmul;

  for (genvar i = FIELD_END; i < FRAME_LEN; i++) begin : g_pad
    assign frame[i] = 1'b0;
  end

endmodule

// File: rtl/bootcfg_clkdiv.sv
module bootcfg_clkdiv #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick,
  output logic sclk
);

  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_nx;

  assign tick   = run && (cnt == LAST);
  assign cnt_nx = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (run) begin
      if (tick) begin
        cnt  <= '0;
        sclk <= 1'b0;
      end else begin
        cnt  <= cnt_nx[CW-1:0];
        sclk <= (cnt_nx >= (CW+1)'(HALF));
      end
    end else begin
      sclk <= 1'b0;
    end
  end

endmodule

// File: rtl/bootcfg_shifter.sv
module bootcfg_shifter #(
  parameter int FRAME_LEN = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic                 tick,
  output logic                 sdata,
  output logic                 busy,
  output logic                 done
);

  localparam int IW = $clog2(FRAME_LEN);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] shreg;
  logic [IW-1:0]        idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      idx   <= '0;
      sdata <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        shreg <= frame;
        idx   <= '0;
        sdata <= frame[0];
        busy  <= 1'b1;
      end else if (tick) begin
        if (idx == LAST_IDX) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          sdata <= 1'b0;
        end else begin
          shreg <= shreg >> 1;
          sdata <= shreg[1];
          idx   <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bootcfg_serializer.sv
module bootcfg_serializer
  import bootcfg_pkg::*;
#(
  parameter int DIV       = 256,
  parameter int FRAME_LEN = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [3:0] cfg_pattern,
  input  logic [2:0] cfg_ratio,
  input  logic       cfg_big_endian,
  input  logic [1:0] cfg_wmode,
  input  logic       cfg_timer_off,
  input  logic       cfg_bus32,
  input  logic [1:0] cfg_drive,
  input  logic [2:0] cfg_wdelay,
  input  logic       cfg_nofastmul,
  output logic       ser_clk,
  output logic       ser_data,
  output logic       busy,
  output logic       done,
  output logic       cfg_err
);

  initial begin
    if (FRAME_LEN < FIELD_END) $error("FRAME_LEN too small for configuration fields");
    if (DIV < 2) $error("DIV must be at least 2");
  end

  bootcfg_t raw_cfg, safe_cfg;
  logic bad_ratio, bad_wmode, bad_pattern;
  logic [FRAME_LEN-1:0] frame;
  logic load, tick;

  always_comb begin
    raw_cfg.pattern    = cfg_pattern;
    raw_cfg.ratio      = cfg_ratio;
    raw_cfg.big_endian = cfg_big_endian;
    raw_cfg.wmode      = cfg_wmode;
    raw_cfg.timer_off  = cfg_timer_off;
    raw_cfg.bus32      = cfg_bus32;
    raw_cfg.drive      = cfg_drive;
    raw_cfg.wdelay     = cfg_wdelay;
    raw_cfg.nofastmul  = cfg_nofastmul;
  end

  assign load = start && !busy;

  bootcfg_validate u_validate (
    .cfg_in      (raw_cfg),
    .cfg_out     (safe_cfg),
    .bad_ratio   (bad_ratio),
    .bad_wmode   (bad_wmode),
    .bad_pattern (bad_pattern)
  );

  bootcfg_frame_build #(.FRAME_LEN(FRAME_LEN)) u_frame (
    .cfg   (safe_cfg),
    .frame (frame)
  );

  bootcfg_clkdiv #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (load),
    .run     (busy),
    .tick    (tick),
    .sclk    (ser_clk)
  );

  bootcfg_shifter #(.FRAME_LEN(FRAME_LEN)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .frame (frame),
    .tick  (tick),
    .sdata (ser_data),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (rst)       cfg_err <= 1'b0;
    else if (load) cfg_err <= bad_ratio || bad_wmode || bad_pattern;
  end

endmodule

// File: rtl/bootcfg_serializer_chk.sv
module bootcfg_serializer_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic tick,
  input logic ser_clk,
  input logic ser_data,
  input logic busy,
  input logic done,
  input logic cfg_err
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                             // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));                            // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!ser_data && !ser_clk));                          // R2
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(tick)) |-> $stable(ser_data)); // R1
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cfg_err));                 // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !tick) |=> busy);                          // R10

endmodule

bind bootcfg_serializer bootcfg_serializer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .tick     (tick),
  .ser_clk  (ser_clk),
  .ser_data (ser_data),
  .busy     (busy),
  .done     (done),
  .cfg_err  (cfg_err)
);

// File: tb/bootcfg_serializer_tb_top.sv
module bootcfg_serializer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int FLEN       = 32;
  localparam int NCYC       = DIV * FLEN;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] cfg_pattern = '0;
  logic [2:0] cfg_ratio = '0;
  logic       cfg_big_endian = 1'b0;
  logic [1:0] cfg_wmode = '0;
  logic       cfg_timer_off = 1'b0;
  logic       cfg_bus32 = 1'b0;
  logic [1:0] cfg_drive = '0;
  logic [2:0] cfg_wdelay = '0;
  logic       cfg_nofastmul = 1'b0;
  logic ser_clk, ser_data, busy, done, cfg_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bootcfg_serializer #(.DIV(DIV), .FRAME_LEN(FLEN)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .cfg_pattern(cfg_pattern), .cfg_ratio(cfg_ratio),
    .cfg_big_endian(cfg_big_endian), .cfg_wmode(cfg_wmode),
    .cfg_timer_off(cfg_timer_off), .cfg_bus32(cfg_bus32),
    .cfg_drive(cfg_drive), .cfg_wdelay(cfg_wdelay),
    .cfg_nofastmul(cfg_nofastmul),
    .ser_clk(ser_clk), .ser_data(ser_data), .busy(busy),
    .done(done), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected frame from the requirement text, built arithmetically
  function automatic longint exp_frame(int pat, int rat, int endi, int wm,
                                       int tim, int bus, int drv, int dly, int nfm);
    longint f = 0;
    if (pat > 8) pat = 0;   // R8
    if (rat == 7) rat = 0;  // R6
    if (wm == 1) wm = 0;    // R7
    f += longint'(pat) * 2;        // bits 4..1
    f += longint'(rat) * 32;       // bits 7..5
    f += longint'(endi) * 256;     // bit 8
    f += longint'(wm) * 512;       // bits 10..9
    f += longint'(tim) * 2048;     // bit 11
    f += longint'(bus) * 4096;     // bit 12
    f += longint'(drv) * 8192;     // bits 14..13
    f += longint'(dly) * 32768;    // bits 17..15
    f += longint'(nfm) * 524288;   // bit 19
    return f;
  endfunction

  task automatic run_frame(input int pat, input int rat, input int endi, input int wm,
                           input int tim, input int bus, input int drv, input int dly,
                           input int nfm, input bit poke_mid);
    longint f = exp_frame(pat, rat, endi, wm, tim, bus, drv, dly, nfm);
    int err = (pat > 8 || rat == 7 || wm == 1) ? 1 : 0;
    int mism = 0;
    @(negedge clk);
    cfg_pattern = 4'(pat); cfg_ratio = 3'(rat); cfg_big_endian = 1'(endi);
    cfg_wmode = 2'(wm); cfg_timer_off = 1'(tim); cfg_bus32 = 1'(bus);
    cfg_drive = 2'(drv); cfg_wdelay = 3'(dly); cfg_nofastmul = 1'(nfm);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 cfg_err at frame start", int'(cfg_err), err);
    for (int k = 0; k <= NCYC; k++) begin
      if (k < NCYC) begin
        int b = k / DIV;
        int eb = int'((f >> b) & 1);
        // R1 R3 R4 R5 data, R2 serial clock phase, R9 busy/done
        if (ser_data !== 1'(eb) || ser_clk !== ((k % DIV) >= DIV/2) ||
            busy !== 1'b1 || done !== 1'b0) begin
          mism++;
          if (mism < 4)
            $display("FAIL R1/R2/R3/R4/R5 cycle %0d bit %0d actual=%b%b%b%b expected=%b%b10",
                     k, b, ser_data, ser_clk, busy, done, 1'(eb), ((k % DIV) >= DIV/2));
        end
        if (poke_mid && k == 10) begin
          // R10: request while busy, with different inputs
          start = 1'b1; cfg_pattern = 4'(~pat); cfg_ratio = 3'(~rat);
          cfg_wmode = 2'(~wm); cfg_nofastmul = 1'(~nfm);
        end
        if (poke_mid && k == 11) start = 1'b0;
      end else begin
        check("R9 done pulse at end", int'(done), 1);
        check("R9 busy falls with done", int'(busy), 0);
        check("R2 idle lines low", int'({ser_data, ser_clk}), 0);
      end
      @(negedge clk);
    end
    n_cmp++;
    if (mism != 0) n_bad++;
    check("R9 done lasts one cycle", int'(done), 0);
    check("R11 cfg_err holds after frame", int'(cfg_err), err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 reset outputs",
          int'({ser_clk, ser_data, busy, done, cfg_err}), 0);
    // Sweep: every pattern code; ratio and write mode cycle incl. reserved (R3 R4 R6 R7 R8)
    for (int p = 0; p < 16; p++) begin
      run_frame(p, p % 8, p & 1, (p / 2) % 4, (p >> 1) & 1, (p >> 2) & 1,
                (p * 3) % 4, (p * 5) % 8, (p >> 3) & 1, 1'b0);
    end
    // R5: all-ones request; only configured positions may be set
    run_frame(8, 6, 1, 3, 1, 1, 3, 7, 1, 1'b0);
    // R6 alone
    run_frame(2, 7, 0, 2, 0, 0, 0, 0, 0, 1'b0);
    // R7 alone
    run_frame(3, 1, 1, 1, 0, 1, 2, 3, 0, 1'b0);
    // R10 request mid-frame is ignored; frame follows first request
    run_frame(5, 4, 1, 3, 1, 0, 1, 6, 0, 1'b1);
    // R11 error clears on next clean frame
    run_frame(0, 0, 0, 0, 0, 0, 0, 0, 0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule